// File: doc/BRIEF.md
# Flash power-up write-inhibit controller

This block sits in front of the instruction path of a serial flash memory. It decides when the device may respond after the supply comes up. Two comparator flags come from outside. The first reports that the supply is above the reset threshold. The second reports that the supply is above the minimum operating level. While the reset flag is low, or while the two flags contradict each other, the internal core is held in reset and no instruction gets any response.

Two independent cycle-count delays run from the two flags. A settle delay starts when the minimum-level flag rises, and it gates read-class instructions. A write-inhibit delay starts when the reset flag rises, and it gates write-class instructions together with the settle delay. Every decoded opcode that arrives outside reset produces exactly one pulse: accept or drop. When the core leaves reset, the block pulses a load strobe next to the initial status word, so the status and lock registers downstream start from a known state.

Top module: `flash_pwrup_guard`

## Requirements
- R1: While `vdd_por_ok` is 0 or `rst` is 1, `core_rst` is 1, `read_ok` and `write_ok` are 0, and a valid opcode produces neither `cmd_accept` nor `cmd_drop`.
- R2: The write-class opcodes are 06h, 02h, A2h, 42h, 20h, D8h, C7h, 01h and E5h. Any one of them that arrives while `write_ok` is 0 (and outside reset) produces `cmd_drop`.
- R3: Every other opcode is read-class. `read_ok` rises after `vdd_min_ok` has been sampled high (with `vdd_por_ok` high) on T_VSL_CYC consecutive clock edges, even when the write-inhibit delay is still running.
- R4: `write_ok` is 1 only when both delays have expired. The write-inhibit delay is T_PUW_CYC consecutive edges with `vdd_por_ok` high. So `write_ok` follows whichever delay finishes later.
- R5: An opcode with `op_valid` high at a clock edge yields, in the next cycle, a one-cycle `cmd_accept` if its class is permitted and a one-cycle `cmd_drop` otherwise. The two pulses are never high together.
- R6: Each delay counter clears on a clock edge where its own flag is low and restarts from zero. A drop of `vdd_min_ok` alone does not restart the write-inhibit delay.
- R7: `vdd_min_ok` high while `vdd_por_ok` is low is a fault. `core_rst` stays 1 until the flags agree.
- R8: In the cycle where `core_rst` falls, `init_load` is 1 for exactly one cycle and `init_status` is all zero. This encodes standby (deep power-down bit 0), write enable latch 0, write in progress 0, and every lock register at write-lock 0 and lock-down 0.
- R9: When `vdd_por_ok` falls during operation, `core_rst` rises and `read_ok`/`write_ok` fall in that same cycle, before any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_por_ok | input | 1 | Supply above reset threshold |
| vdd_min_ok | input | 1 | Supply above minimum operating level |
| op_valid | input | 1 | Decoded opcode strobe |
| op_code | input | 8 | Decoded opcode |
| core_rst | output | 1 | Hold for the internal core |
| read_ok | output | 1 | Read-class instructions permitted |
| write_ok | output | 1 | Write-class instructions permitted |
| cmd_accept | output | 1 | One-cycle pulse: opcode permitted |
| cmd_drop | output | 1 | One-cycle pulse: opcode rejected |
| init_load | output | 1 | One-cycle strobe when core leaves reset |
| init_status | output | 3+2*N_LOCK | Initial {deep_pd, wel, wip, lock pairs} |

## Verification
The bench builds the block with T_PUW_CYC = 20, T_VSL_CYC = 8 and N_LOCK = 2. These short delays let it reach both orderings of the two expirations within a few dozen cycles. With an early minimum-level rise, reads open well before writes. With a late rise, the settle delay finishes last and holds writes back on its own. The small values also let the bench probe each delay one cycle before and exactly at its boundary, after restarts caused by a supply drop and by a brief minimum-level glitch.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef struct packed {
        logic deep_pd;
        logic wel;
        logic wip;
    } pwr_flags_t;

    localparam pwr_flags_t FLAGS_AT_START = '{deep_pd: 1'b0, wel: 1'b0, wip: 1'b0};

    typedef enum logic [1:0] {
        OPC_NONE  = 2'd0,
        OPC_READ  = 2'd1,
        OPC_WRITE = 2'd2
    } op_class_e;

    function automatic logic is_write_op(input logic [7:0] code);
        case (code)
            8'h06, 8'h02, 8'hA2, 8'h42, 8'h20,
            8'hD8, 8'hC7, 8'h01, 8'hE5: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    function automatic op_class_e classify(input logic valid, input logic [7:0] code);
        if (!valid)              return OPC_NONE;
        else if (is_write_op(code)) return OPC_WRITE;
        else                     return OPC_READ;
    endfunction

endpackage

// File: rtl/pwr_delay_timer.sv
module pwr_delay_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] LIMIT = W'(CYCLES);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIMIT);

    assert_clear_on_low_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> !done);
    assert_hold_done_R6: assert property (@(posedge clk) disable iff (rst)
        (done && run) |=> done);

endmodule

// File: rtl/pwr_cmd_gate.sv
module pwr_cmd_gate
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       core_rst,
    input  logic       read_ok,
    input  logic       write_ok,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    output logic       cmd_accept,
    output logic       cmd_drop
);
    op_class_e cls;
    logic      permitted;

    always_comb begin
        cls = classify(op_valid, op_code);
        unique case (cls)
            OPC_READ:  permitted = read_ok;
            OPC_WRITE: permitted = write_ok;
            default:   permitted = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || core_rst || cls == OPC_NONE) begin
            cmd_accept <= 1'b0;
            cmd_drop   <= 1'b0;
        end else begin
            cmd_accept <= permitted;
            cmd_drop   <= !permitted;
        end
    end

    assert_write_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !core_rst && is_write_op(op_code) && !write_ok) |=> cmd_drop);
    assert_silent_in_reset_R1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && core_rst) |=> (!cmd_accept && !cmd_drop));
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        !(cmd_accept && cmd_drop));

endmodule

// File: rtl/flash_pwrup_guard.sv
module flash_pwrup_guard
    import pwrseq_pkg::*;
#(
    parameter int T_PUW_CYC = 20,
    parameter int T_VSL_CYC = 8,
    parameter int N_LOCK    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  vdd_por_ok,
    input  logic                  vdd_min_ok,
    input  logic                  op_valid,
    input  logic [7:0]            op_code,
    output logic                  core_rst,
    output logic                  read_ok,
    output logic                  write_ok,
    output logic                  cmd_accept,
    output logic                  cmd_drop,
    output logic                  init_load,
    output logic [3+2*N_LOCK-1:0] init_status
);
    localparam int LOCK_W = 2 * N_LOCK;

    logic fault;
    logic puw_done, vsl_done;
    logic core_rst_q;
    logic [LOCK_W-1:0] lock_start;

    assign fault    = vdd_min_ok && !vdd_por_ok;
    assign core_rst = rst || !vdd_por_ok || fault;

    pwr_delay_timer #(.CYCLES(T_PUW_CYC)) u_puw (
        .clk (clk),
        .rst (rst),
        .run (vdd_por_ok),
        .done(puw_done)
    );

    pwr_delay_timer #(.CYCLES(T_VSL_CYC)) u_vsl (
        .clk (clk),
        .rst (rst),
        .run (vdd_min_ok && vdd_por_ok),
        .done(vsl_done)
    );

    assign read_ok  = vsl_done && !core_rst;
    assign write_ok = vsl_done && puw_done && !core_rst;

    pwr_cmd_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .core_rst  (core_rst),
        .read_ok   (read_ok),
        .write_ok  (write_ok),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .cmd_accept(cmd_accept),
        .cmd_drop  (cmd_drop)
    );

    always_ff @(posedge clk) begin
        if (rst) core_rst_q <= 1'b1;
        else     core_rst_q <= core_rst;
    end

    generate
        for (genvar i = 0; i < N_LOCK; i++) begin : g_lock
            assign lock_start[2*i+1] = 1'b0;
            assign lock_start[2*i]   = 1'b0;
        end
    endgenerate

    assign init_load   = core_rst_q && !core_rst;
    assign init_status = {FLAGS_AT_START, lock_start};

    assert_write_implies_read_R4: assert property (@(posedge clk) disable iff (rst)
        write_ok |-> read_ok);
    assert_fault_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (vdd_min_ok && !vdd_por_ok) |-> (core_rst && !read_ok));
    assert_por_low_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        !vdd_por_ok |-> (!read_ok && !write_ok));
    assert_load_once_R8: assert property (@(posedge clk) disable iff (rst)
        init_load |=> !init_load);

endmodule

// File: tb/tb_flash_pwrup_guard.sv
module tb_flash_pwrup_guard;
    localparam int CLK_PERIOD = 10;
    localparam int PUW = 20;
    localparam int VSL = 8;
    localparam int NL  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por = 1'b0;
    logic vmin = 1'b0;
    logic op_valid = 1'b0;
    logic [7:0] op_code = 8'h00;
    logic core_rst, read_ok, write_ok, cmd_accept, cmd_drop, init_load;
    logic [3+2*NL-1:0] init_status;

    int checks = 0;
    int errors = 0;
    int k = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pwrup_guard #(.T_PUW_CYC(PUW), .T_VSL_CYC(VSL), .N_LOCK(NL)) dut (
        .clk(clk), .rst(rst), .vdd_por_ok(por), .vdd_min_ok(vmin),
        .op_valid(op_valid), .op_code(op_code), .core_rst(core_rst),
        .read_ok(read_ok), .write_ok(write_ok), .cmd_accept(cmd_accept),
        .cmd_drop(cmd_drop), .init_load(init_load), .init_status(init_status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (k=%0d)", req, act, exp, k);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        k++;
    endtask

    task automatic wait_to(input int n);
        while (k < n) tick();
    endtask

    // send one opcode, check the pulse pair in the following cycle
    task automatic send_op(input logic [7:0] code, input logic exp_acc,
                           input logic exp_drop, input string req);
        op_valid = 1'b1;
        op_code  = code;
        tick();
        op_valid = 1'b0;
        #1;
        check(req, {cmd_accept, cmd_drop}, {exp_acc, exp_drop});
    endtask

    task automatic power_off();
        @(negedge clk);
        por = 1'b0;
        vmin = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 core_rst in reset", core_rst, 1);
        check("R1 read_ok in reset", read_ok, 0);
        check("R1 write_ok in reset", write_ok, 0);
        rst = 1'b0;
        @(negedge clk);
        send_op(8'h03, 0, 0, "R1 no response with supply low");
        send_op(8'h06, 0, 0, "R1 no response to write with supply low");
    endtask

    task automatic t_early_min();
        power_off();
        por = 1'b1;
        k = 0;
        #1;
        check("R8 init_load on release", init_load, 1);
        check("R8 init_status zero", init_status, 0);
        check("R8 core_rst released", core_rst, 0);
        wait_to(1);
        #1;
        check("R8 init_load one cycle", init_load, 0);
        wait_to(2);
        vmin = 1'b1;
        wait_to(4);
        send_op(8'h03, 0, 1, "R3 read dropped before settle");
        wait_to(9);
        check("R3 read_ok one before boundary", read_ok, 0);
        wait_to(10);
        check("R3 read_ok at boundary", read_ok, 1);
        check("R3 write_ok still low", write_ok, 0);
        send_op(8'h0B, 1, 0, "R3 read accepted while writes inhibited");
        send_op(8'h06, 0, 1, "R2 write enable dropped");
        send_op(8'hD8, 0, 1, "R2 sector erase dropped");
        wait_to(19);
        check("R4 write_ok one before boundary", write_ok, 0);
        wait_to(20);
        check("R4 write_ok at boundary", write_ok, 1);
        send_op(8'h02, 1, 0, "R2 page program accepted after delay");
        send_op(8'hC7, 1, 0, "R2 bulk erase accepted after delay");
        wait_to(24);
        #1;
        check("R5 pulse lasts one cycle", {cmd_accept, cmd_drop}, 2'b00);
    endtask

    task automatic t_late_min();
        power_off();
        por = 1'b1;
        k = 0;
        wait_to(15);
        vmin = 1'b1;
        wait_to(20);
        send_op(8'h20, 0, 1, "R4 write dropped while settle runs");
        wait_to(22);
        check("R4 write_ok held by late settle", write_ok, 0);
        check("R3 read_ok before settle", read_ok, 0);
        wait_to(23);
        check("R4 write_ok when later delay ends", write_ok, 1);
        check("R3 read_ok when settle ends", read_ok, 1);
        send_op(8'h42, 1, 0, "R2 otp program accepted");
        send_op(8'hE5, 1, 0, "R2 lock write accepted");
        send_op(8'h01, 1, 0, "R2 status write accepted");
        send_op(8'hA2, 1, 0, "R2 dual program accepted");
    endtask

    task automatic t_por_drop();
        por = 1'b0;
        #1;
        check("R9 core_rst immediate", core_rst, 1);
        check("R9 read_ok immediate", read_ok, 0);
        check("R9 write_ok immediate", write_ok, 0);
        vmin = 1'b0;
        send_op(8'h03, 0, 0, "R1 silent after supply loss");
        @(negedge clk);
        por = 1'b1;
        vmin = 1'b1;
        k = 0;
        wait_to(VSL);
        check("R6 read_ok after restart", read_ok, 1);
        wait_to(PUW - 1);
        check("R6 write delay restarted", write_ok, 0);
        wait_to(PUW);
        check("R6 write_ok after restart", write_ok, 1);
    endtask

    task automatic t_min_glitch();
        vmin = 1'b0;
        tick();
        #1;
        check("R6 read_ok cleared by glitch", read_ok, 0);
        check("R6 write_ok cleared by glitch", write_ok, 0);
        check("R6 core stays out of reset", core_rst, 0);
        vmin = 1'b1;
        k = 0;
        wait_to(VSL - 1);
        check("R6 settle restarted", read_ok, 0);
        wait_to(VSL);
        check("R6 settle done again", read_ok, 1);
        check("R6 write delay not restarted by glitch", write_ok, 1);
    endtask

    task automatic t_fault();
        power_off();
        vmin = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 fault holds core_rst", core_rst, 1);
        check("R7 fault read_ok low", read_ok, 0);
        send_op(8'h03, 0, 0, "R7 silent under fault");
        por = 1'b1;
        k = 0;
        #1;
        check("R7 release when flags agree", core_rst, 0);
        check("R8 init_load after fault", init_load, 1);
        wait_to(VSL - 1);
        check("R7 settle counts from agreement", read_ok, 0);
        wait_to(VSL);
        check("R7 read_ok after fault", read_ok, 1);
    endtask

    task automatic t_sync_reset();
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R1 rst forces core_rst", core_rst, 1);
        check("R1 rst blocks reads", read_ok, 0);
        tick();
        rst = 1'b0;
        #1;
        check("R8 init_load after rst", init_load, 1);
        check("R1 delays cleared by rst", read_ok, 0);
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none
        t_reset();
        t_early_min();
        t_late_min();
        t_por_drop();
        t_min_glitch();
        t_fault();
        t_sync_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule